// File: doc/BRIEF.md
# Power mode control register

This block is the byte-wide power-control register of a small 8-bit microcontroller core. Software writes it through a simple register port to set a serial baud-rate doubler, to keep two free flags, and to request one of two low-power modes. The two request bits are triggers, not storage. A write of 1 starts the mode, and the bits always read back as zero. The mode itself lives in separate internal flip-flops.

Idle mode freezes the CPU, both basic timers and the serial port, and leaves the rest of the chip running. It ends when either of two wake interrupts arrives: an auxiliary interrupt or an external wake-up interrupt. Stop mode halts the oscillator, freezes the peripherals and holds the I/O pins. Only reset ends stop mode. The block drives registered active-high freeze and gate enables. The oscillator, analog references and CPU pipeline are outside the block.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset, rd_data reads 0x30, baud_dbl and user_flags are 0, and all six hold/gate outputs are 0.
- R2: Bit 7 is writable and reads back as written. baud_dbl follows it: 1 selects the doubled serial rate, 0 the standard rate.
- R3: Bits 3 and 2 are free software flags. They read back as written and appear on user_flags[1] and user_flags[0].
- R4: Whatever is written, bits 5 and 4 read 1 and bits 6, 1 and 0 read 0. rd_data therefore equals (written & 0x8C) | 0x30.
- R5: A write with bit 0 = 1 enters idle. cpu_hold, tmr_hold and ser_hold are still 0 at the edge that captures the write and are 1 from the following edge.
- R6: In idle without stop, osc_off, periph_hold and pin_hold stay 0.
- R7: In idle, a 1 on wake_aux or wake_ext clears the idle state at the edge that samples it. The idle holds drop one edge later, and the readable bits are unchanged.
- R8: A write with bit 1 = 1 enters stop, which drives all six outputs to 1 from the edge after the capturing edge. Stop takes precedence over idle when both bits are written together.
- R9: In stop, wake_aux and wake_ext have no effect. Only reset returns the outputs to 0.
- R10: In stop, register writes are ignored and rd_data does not change.
- R11: An idle request and a wake pulse sampled on the same edge enter idle, because the request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| wake_aux | input | 1 | Auxiliary interrupt wake request |
| wake_ext | input | 1 | External wake-up interrupt request |
| baud_dbl | output | 1 | Serial baud-rate doubler enable |
| user_flags | output | 2 | Software flag bits |
| cpu_hold | output | 1 | CPU freeze |
| tmr_hold | output | 1 | Timer 0 and 1 freeze |
| ser_hold | output | 1 | Serial port freeze |
| osc_off | output | 1 | Oscillator halt and external clock block |
| periph_hold | output | 1 | Peripheral freeze |
| pin_hold | output | 1 | I/O pin state hold |

## Verification
A mode flop left in the wrong state shows on the hold outputs exactly one edge after the flop changes. A stuck idle flop keeps cpu_hold high one edge after a wake. A lost stop flop lets osc_off fall, or lets rd_data take a write, while the chip should still be stopped. A wrong readable bit shows on rd_data at once, because reads are combinational from the stored bits. All 256 write values are swept from reset, and each non-zero mode is followed by its exit path, so every such fault becomes visible within two clocks of the stimulus.

// File: rtl/pmc_pkg.sv
// Package: shared constants and types for the power mode control register.
// Assumes an 8-bit register whose bit positions are fixed by software use.
package pmc_pkg;
    localparam int REG_W     = 8;
    localparam int BIT_DBL   = 7;
    localparam int FLAG_LSB  = 2;
    localparam int NUM_FLAGS = 2;
    localparam int BIT_STOP  = 1;
    localparam int BIT_IDLE  = 0;
    localparam logic [REG_W-1:0] FIXED_ONES = 8'h30;

    // Registered freeze and gate enables, all active high.
    typedef struct packed {
        logic cpu;
        logic tmr;
        logic ser;
        logic osc;
        logic per;
        logic pin;
    } gate_t;
endpackage

// File: rtl/pmc_cfg_reg.sv
// pmc_cfg_reg: the readable and writable bits of the power register.
// It holds the baud doubler and the software flags and assembles the read value
// with the constant bits. Assumes wr_ok is already masked while stopped.
module pmc_cfg_reg
    import pmc_pkg::*;
#(
    parameter int W      = REG_W,
    parameter int NFLAGS = NUM_FLAGS,
    parameter int FLSB   = FLAG_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [W-1:0]      wr_data,
    output logic              dbl,
    output logic [NFLAGS-1:0] flags,
    output logic [W-1:0]      rd_data
);
    logic              dbl_q;
    logic [NFLAGS-1:0] flag_q;

    // Purpose: capture the doubler bit on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dbl_q <= 1'b0;
        else if (wr_ok)
            dbl_q <= wr_data[BIT_DBL];
    end

    // One storage flop per software flag.
    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
        // Purpose: capture one software flag on an accepted write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[g] <= 1'b0;
            else if (wr_ok)
                flag_q[g] <= wr_data[FLSB+g];
        end
    end

    // Purpose: build the read value from the constant bits and the stored bits.
    always_comb begin
        rd_data          = FIXED_ONES;
        rd_data[BIT_DBL] = dbl_q;
        for (int i = 0; i < NFLAGS; i++)
            rd_data[FLSB+i] = flag_q[i];
    end

    assign dbl   = dbl_q;
    assign flags = flag_q;
endmodule

// File: rtl/pmc_mode_ctl.sv
// pmc_mode_ctl: the idle and stop state flops, kept apart from the readable bits.
// Stop is sticky until reset and also clears idle. An idle request beats a wake
// sampled on the same edge. Assumes the requests are already masked while stopped.
module pmc_mode_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_idle,
    input  logic req_stop,
    input  logic wake,
    output logic idle_q,
    output logic stop_q
);
    // Purpose: enter stop on request; only reset leaves it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stop_q <= 1'b0;
        else if (req_stop)
            stop_q <= 1'b1;
    end

    // Purpose: track idle; stop overrides it, a request sets it, a wake clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idle_q <= 1'b0;
        else if (stop_q || req_stop)
            idle_q <= 1'b0;
        else if (req_idle)
            idle_q <= 1'b1;
        else if (wake)
            idle_q <= 1'b0;
    end
endmodule

// File: rtl/pmc_gate_out.sv
// pmc_gate_out: registers the freeze and gate enables from the mode state.
// Idle freezes the CPU, the timers and the serial port. Stop freezes all of
// these and adds the oscillator halt, the peripheral freeze and the pin hold.
module pmc_gate_out
    import pmc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  idle,
    input  logic  stop,
    output gate_t gate
);
    gate_t nxt;

    // Purpose: map the mode state onto the individual enables.
    always_comb begin
        nxt.cpu = idle | stop;
        nxt.tmr = idle | stop;
        nxt.ser = idle | stop;
        nxt.osc = stop;
        nxt.per = stop;
        nxt.pin = stop;
    end

    // Purpose: register the enables so the outputs are glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate <= '0;
        else
            gate <= nxt;
    end
endmodule

// File: rtl/pwr_mode_ctl.sv
// pwr_mode_ctl: top of the power mode control register.
// Decodes register writes into configuration updates and mode requests, merges
// the two wake sources, and brings out the registered freeze enables.
// Assumes single-cycle write strobes in the clk domain and synchronous wakes.
module pwr_mode_ctl
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             wake_aux,
    input  logic             wake_ext,
    output logic             baud_dbl,
    output logic [NUM_FLAGS-1:0] user_flags,
    output logic             cpu_hold,
    output logic             tmr_hold,
    output logic             ser_hold,
    output logic             osc_off,
    output logic             periph_hold,
    output logic             pin_hold
);
    logic  idle_q;
    logic  stop_q;
    logic  wr_ok;
    logic  wake_any;
    gate_t gate;

    // Purpose: accept writes only while the clock domain is not stopped.
    assign wr_ok    = wr_en & ~stop_q;
    assign wake_any = wake_aux | wake_ext;

    pmc_cfg_reg #(
        .W      (REG_W),
        .NFLAGS (NUM_FLAGS),
        .FLSB   (FLAG_LSB)
    ) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (wr_ok),
        .wr_data (wr_data),
        .dbl     (baud_dbl),
        .flags   (user_flags),
        .rd_data (rd_data)
    );

    pmc_mode_ctl i_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_idle (wr_ok & wr_data[BIT_IDLE]),
        .req_stop (wr_ok & wr_data[BIT_STOP]),
        .wake     (wake_any),
        .idle_q   (idle_q),
        .stop_q   (stop_q)
    );

    pmc_gate_out i_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .idle  (idle_q),
        .stop  (stop_q),
        .gate  (gate)
    );

    assign cpu_hold    = gate.cpu;
    assign tmr_hold    = gate.tmr;
    assign ser_hold    = gate.ser;
    assign osc_off     = gate.osc;
    assign periph_hold = gate.per;
    assign pin_hold    = gate.pin;
endmodule

// File: rtl/pmc_checker.sv
// pmc_checker: port-level properties of pwr_mode_ctl, attached with bind.
module pmc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       wake_aux,
    input logic       wake_ext,
    input logic       cpu_hold,
    input logic       periph_hold,
    input logic       pin_hold,
    input logic       osc_off
);
    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[5:4] == 2'b11) && (rd_data[6] == 1'b0) && (rd_data[1:0] == 2'b00)); // R4
    AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[0]) |=> ##1 cpu_hold); // R5
    AST_IDLE_LIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_hold && !osc_off) |-> (!periph_hold && !pin_hold)); // R6
    AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((wake_aux || wake_ext) && !wr_en) |=> ##1 (!cpu_hold || osc_off)); // R7
    AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[1]) |=> ##1 osc_off); // R8
    AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        osc_off |=> osc_off); // R9
    AST_STOP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        osc_off |=> $stable(rd_data)); // R10
endmodule

bind pwr_mode_ctl pmc_checker i_pmc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .wake_aux    (wake_aux),
    .wake_ext    (wake_ext),
    .cpu_hold    (cpu_hold),
    .periph_hold (periph_hold),
    .pin_hold    (pin_hold),
    .osc_off     (osc_off)
);

// File: tb/test_pwr_mode_ctl.sv
// Bench: sweeps every write value from reset and follows each mode to its exit.
module test_pwr_mode_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wake_aux = 1'b0;
    logic       wake_ext = 1'b0;
    logic [7:0] rd_data;
    logic       baud_dbl;
    logic [1:0] user_flags;
    logic       cpu_hold, tmr_hold, ser_hold, osc_off, periph_hold, pin_hold;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    pwr_mode_ctl i_pwr_mode_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .wake_aux(wake_aux), .wake_ext(wake_ext),
        .baud_dbl(baud_dbl), .user_flags(user_flags),
        .cpu_hold(cpu_hold), .tmr_hold(tmr_hold), .ser_hold(ser_hold),
        .osc_off(osc_off), .periph_hold(periph_hold), .pin_hold(pin_hold)
    );

    function automatic logic [7:0] holds();
        return {2'b00, cpu_hold, tmr_hold, ser_hold, osc_off, periph_hold, pin_hold};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk) begin wr_en = 1'b1; wr_data = v; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        do_reset();
        chk("R1 rd_data", rd_data, 8'h30);
        chk("R1 holds", holds(), 8'h00);
        chk("R1 doubler/flags", {5'b0, baud_dbl, user_flags}, 8'h00);

        for (int v = 0; v < 256; v++) begin
            logic [7:0] val, exp_rd, exp_h;
            val    = 8'(v);
            exp_rd = (val & 8'h8C) | 8'h30;
            exp_h  = val[1] ? 8'h3F : (val[0] ? 8'h38 : 8'h00);
            do_reset();
            do_write(val);
            chk("R4 rd_data", rd_data, exp_rd);
            chk("R2 baud_dbl", {7'b0, baud_dbl}, {7'b0, val[7]});
            chk("R3 user_flags", {6'b0, user_flags}, {6'b0, val[3:2]});
            chk("R5 hold latency", holds(), 8'h00);
            @(negedge clk);
            chk(val[1] ? "R8 stop holds" : "R5 R6 idle holds", holds(), exp_h);
            if (val[1]) begin
                @(negedge clk) begin wake_aux = 1'b1; wake_ext = 1'b1; end
                @(negedge clk) begin wake_aux = 1'b0; wake_ext = 1'b0; end
                @(negedge clk);
                chk("R9 wake in stop", holds(), 8'h3F);
                do_write(~val);
                @(negedge clk);
                chk("R10 write in stop", rd_data, exp_rd);
                chk("R9 still stopped", holds(), 8'h3F);
                do_reset();
                chk("R9 reset exit", holds(), 8'h00);
                chk("R1 reset rd", rd_data, 8'h30);
            end else if (val[0]) begin
                @(negedge clk) begin wake_aux = val[7]; wake_ext = ~val[7]; end
                @(negedge clk) begin wake_aux = 1'b0; wake_ext = 1'b0; end
                chk("R7 holds before drop", holds(), 8'h38);
                @(negedge clk);
                chk("R7 holds after wake", holds(), 8'h00);
                chk("R7 rd kept", rd_data, exp_rd);
            end
        end

        do_reset();
        @(negedge clk) begin wr_en = 1'b1; wr_data = 8'h01; wake_aux = 1'b1; end
        @(negedge clk) begin wr_en = 1'b0; wake_aux = 1'b0; end
        @(negedge clk);
        chk("R11 request beats wake", holds(), 8'h38);

        done = 1'b1;
        summary();
    end
endmodule